// File: doc/BRIEF.md
# EEPROM Write-Protect Gate

This block decides, byte by byte, whether an I2C write aimed at the external identification EEPROM may go on to the EEPROM-side master. It sits behind one or more decoded I2C slave ports. Source 0 is the control port and source 1 is the port-A DDC lines. Each port delivers a stream of events: start, device address, data byte and stop. The block holds a single password register. The register is reached only through the device's own control address. While the register holds the unlock key, writes to the EEPROM address pass through. In every other case they are refused and counted.

An EEPROM write carries a word offset followed by one data byte. Any byte beyond these two ends the forwarding for that transaction, and the block counts one rejection. Only one source can own the EEPROM path at a time. The block also reports whether the gate is currently open, so that the lock state can be seen at the ports.

Top module: `eeprom_wr_gate`

## Requirements
- R1: After reset the gate is locked (`gate_open`=0), `rej_count` is 0 and nothing is forwarded.
- R2: A data byte that lands at register offset 0x0F of control address 0x98 sets the gate. The gate is open from the next cycle if the byte is 0x96, and locked for any other value, including 0x00.
- R3: In a control-address write, the first data byte loads a register pointer. Each later byte is stored at the pointer, and the pointer then increments. Only the byte stored at 0x0F changes the lock state. The lock state holds otherwise.
- R4: Writing 0x96 at offset 0x0F through the EEPROM address 0xA0 is ordinary EEPROM traffic and does not open the gate.
- R5: While the gate is locked, the address phase of a write to 0xA0 (address byte 0xA0, R/W bit 0) is rejected. Nothing of that transaction is forwarded, `rej_pulse` rises for one cycle and `rej_count` increments once.
- R6: While the gate is open, the transaction owner's first and second bytes after 0xA0 are forwarded one cycle after they arrive. `fwd_first` is 1 for the word offset and 0 for the data byte, and `fwd_src` gives the source index.
- R7: The third and any later byte of an EEPROM write is not forwarded. The first excess byte produces one rejection, and further bytes add none.
- R8: A stop or repeated start from the owning source produces a one-cycle `fwd_end` one cycle later. The same events from other sources do not.
- R9: A source that addresses 0xA0 while another source owns the path is rejected. When both address 0xA0 in the same cycle, source 0 gets the path and the other is rejected.
- R10: The lock state is checked again on every forwarded byte, using the state held before that cycle. A byte in the same cycle as a relocking password write is still forwarded. The next byte is rejected once, and later bytes are dropped without counting.
- R11: When both sources store to offset 0x0F in the same cycle, the value from source 0 decides the lock state.
- R12: `rej_count` adds the number of rejections in each cycle (two sources may add 2 at once) and saturates at its maximum. `rej_pulse` marks any cycle that had a rejection.
- R13: Reads (address 0xA1) and writes to other device addresses forward nothing and count nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_start | input | SRC_N | Start or repeated start seen, one bit per source |
| src_stop | input | SRC_N | Stop seen, one bit per source |
| src_addr_vld | input | SRC_N | Address byte valid, one bit per source |
| src_addr | input | 8*SRC_N | Address byte including R/W bit, 8 bits per source |
| src_dat_vld | input | SRC_N | Data byte valid, one bit per source |
| src_dat | input | 8*SRC_N | Data byte, 8 bits per source |
| fwd_vld | output | 1 | A byte is forwarded to the EEPROM master |
| fwd_first | output | 1 | Forwarded byte is the word offset |
| fwd_data | output | 8 | Forwarded byte |
| fwd_src | output | clog2(SRC_N) | Source that owns the forwarded transaction |
| fwd_end | output | 1 | Owning transaction has ended |
| rej_pulse | output | 1 | At least one rejection in the previous cycle |
| rej_count | output | CNT_W | Saturating rejection counter |
| gate_open | output | 1 | Password register holds the unlock key |

## Verification
Two functions can fall in the same cycle: a relocking password write from one source and an EEPROM byte from the other source that owns the path. The bench opens the gate and gives the EEPROM path to source 0. It then times source 1's 0x00 store at 0x0F to land in the same cycle as source 0's word offset. The bench expects the word offset to be forwarded and `gate_open` to fall. On the following byte it expects exactly one rejection, and none on the bytes after that. The same arbitration is also provoked by simultaneous EEPROM address phases, which should yield one grant to source 0 and one counted rejection, and by simultaneous password stores, where the value from source 0 should decide the lock state.

// File: rtl/wpg_pkg.sv
// Package: shared types and constants for the EEPROM write-protect gate.
// Assumes byte-wide I2C payloads.
package wpg_pkg;

    localparam int BYTE_W = 8;

    // Transaction mode tracked by each source parser.
    typedef enum logic [1:0] {
        PM_IDLE = 2'd0,   // waiting for an address byte
        PM_CTRL = 2'd1,   // write to the device control address
        PM_EEP  = 2'd2,   // write to the EEPROM address
        PM_SKIP = 2'd3    // read, or some other device: ignored
    } pmode_e;

endpackage

// File: rtl/wpg_txn_parser.sv
// Module: wpg_txn_parser
// Follows one source's stream of decoded I2C events and sorts each byte into
// control-register stores or EEPROM write bytes. Assumes at most one event
// (start, address, data, stop) per cycle per source. The address byte carries
// the R/W bit in bit 0, so reads never match a write address.
module wpg_txn_parser
    import wpg_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR = 8'h98,
    parameter logic [7:0] EEP_ADDR  = 8'hA0,
    parameter int         BYTE_LIM  = 2,
    localparam int        IDX_W     = $clog2(BYTE_LIM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             addr_vld,
    input  logic [7:0]       addr,
    input  logic             dat_vld,
    input  logic [7:0]       dat,
    output logic             eep_open,
    output logic             txn_end,
    output logic             eep_byte_vld,
    output logic [IDX_W-1:0] eep_idx,
    output logic [7:0]       eep_data,
    output logic             ctl_wr,
    output logic [7:0]       ctl_ptr,
    output logic [7:0]       ctl_data
);

    localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(BYTE_LIM);

    pmode_e           mode_q;
    logic             ptr_ld_q;   // register pointer already loaded
    logic [7:0]       ptr_q;
    logic [IDX_W-1:0] idx_q;

    // Purpose: decode the events of this cycle into the per-byte outputs.
    always_comb begin
        eep_open     = addr_vld && (addr == EEP_ADDR);
        txn_end      = start || stop;
        eep_byte_vld = dat_vld && (mode_q == PM_EEP);
        eep_idx      = idx_q;
        eep_data     = dat;
        ctl_wr       = dat_vld && (mode_q == PM_CTRL) && ptr_ld_q;
        ctl_ptr      = ptr_q;
        ctl_data     = dat;
    end

    // Purpose: track the transaction mode, register pointer and byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= PM_IDLE;
            ptr_ld_q <= 1'b0;
            ptr_q    <= '0;
            idx_q    <= '0;
        end else if (start || stop) begin
            mode_q   <= PM_IDLE;
            ptr_ld_q <= 1'b0;
            idx_q    <= '0;
        end else if (addr_vld) begin
            ptr_ld_q <= 1'b0;
            idx_q    <= '0;
            if (addr == CTRL_ADDR)     mode_q <= PM_CTRL;
            else if (addr == EEP_ADDR) mode_q <= PM_EEP;
            else                       mode_q <= PM_SKIP;
        end else if (dat_vld) begin
            if (mode_q == PM_CTRL) begin
                if (!ptr_ld_q) begin
                    ptr_q    <= dat;
                    ptr_ld_q <= 1'b1;
                end else begin
                    ptr_q <= ptr_q + 8'd1;
                end
            end else if (mode_q == PM_EEP && idx_q != IDX_SAT) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // Consecutive stores within one control transaction walk the pointer.
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && $past(ctl_wr)) |-> (ctl_ptr == $past(ctl_ptr) + 8'd1));

    // An EEPROM address phase restarts the byte index at the word offset.
    assert_idx_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eep_open |=> (eep_idx == '0));

endmodule

// File: rtl/wpg_pw_lock.sv
// Module: wpg_pw_lock
// Holds the write-protect password register. The register accepts stores at
// offset PW_OFF through the control address only. The gate opens when the
// stored value equals PW_KEY. When several sources store in the same cycle,
// the lowest source index wins.
module wpg_pw_lock #(
    parameter int         SRC_N  = 2,
    parameter logic [7:0] PW_OFF = 8'h0F,
    parameter logic [7:0] PW_KEY = 8'h96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_N-1:0]   ctl_wr,
    input  logic [SRC_N*8-1:0] ctl_ptr,
    input  logic [SRC_N*8-1:0] ctl_data,
    output logic               unlocked
);

    logic hit;
    logic next_open;

    // Purpose: choose the winning password store of this cycle, if any.
    always_comb begin
        hit       = 1'b0;
        next_open = unlocked;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (ctl_wr[i] && ctl_ptr[i*8 +: 8] == PW_OFF) begin
                hit       = 1'b1;
                next_open = (ctl_data[i*8 +: 8] == PW_KEY);
            end
        end
    end

    // Purpose: register the lock state; reset leaves the gate locked.
    always_ff @(posedge clk) begin
        if (!rst_n) unlocked <= 1'b0;
        else if (hit) unlocked <= next_open;
    end

    // The key stored by source 0 always opens the gate on the next cycle.
    assert_key_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr[0] && ctl_ptr[7:0] == PW_OFF && ctl_data[7:0] == PW_KEY) |=> unlocked);

    // A cycle without a store at the password offset leaves the state alone.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(unlocked));

endmodule

// File: rtl/wpg_rej_counter.sv
// Module: wpg_rej_counter
// Counts rejections and saturates at the all-ones value. Several sources may
// reject in the same cycle, and each rejection adds one.
module wpg_rej_counter #(
    parameter int SRC_N = 2,
    parameter int CNT_W = 8,
    localparam int ADD_W = $clog2(SRC_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] rej_now,
    output logic             rej_pulse,
    output logic [CNT_W-1:0] rej_count
);

    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [ADD_W-1:0] add_n;
    logic [CNT_W:0]   sum;

    // Purpose: form the unsaturated sum of the count and this cycle's rejections.
    always_comb begin
        add_n = ADD_W'($countones(rej_now));
        sum   = {1'b0, rej_count} + (CNT_W + 1)'(add_n);
    end

    // Purpose: update the saturating counter and the rejection pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej_count <= '0;
            rej_pulse <= 1'b0;
        end else begin
            rej_pulse <= |rej_now;
            rej_count <= (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end

    // The count never falls while out of reset.
    assert_count_mono_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rej_count >= $past(rej_count));

    // A rejection moves the count unless it is already saturated.
    assert_pulse_moves_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rej_pulse |-> (rej_count != $past(rej_count)) || (&rej_count));

endmodule

// File: rtl/eeprom_wr_gate.sv
// Module: eeprom_wr_gate (top)
// Lets I2C writes through to the EEPROM-side master only while the password
// register holds the key. An EEPROM write is limited to its word offset plus
// one data byte. One source owns the EEPROM path from its address phase until
// its stop or repeated start. Source 0 is the control port and has priority.
// Outputs are registered, so each appears one cycle after its cause.
module eeprom_wr_gate #(
    parameter int         SRC_N     = 2,
    parameter logic [7:0] CTRL_ADDR = 8'h98,
    parameter logic [7:0] EEP_ADDR  = 8'hA0,
    parameter logic [7:0] PW_OFF    = 8'h0F,
    parameter logic [7:0] PW_KEY    = 8'h96,
    parameter int         BYTE_LIM  = 2,
    parameter int         CNT_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SRC_N-1:0]         src_start,
    input  logic [SRC_N-1:0]         src_stop,
    input  logic [SRC_N-1:0]         src_addr_vld,
    input  logic [SRC_N*8-1:0]       src_addr,
    input  logic [SRC_N-1:0]         src_dat_vld,
    input  logic [SRC_N*8-1:0]       src_dat,
    output logic                     fwd_vld,
    output logic                     fwd_first,
    output logic [7:0]               fwd_data,
    output logic [$clog2(SRC_N)-1:0] fwd_src,
    output logic                     fwd_end,
    output logic                     rej_pulse,
    output logic [CNT_W-1:0]         rej_count,
    output logic                     gate_open
);

    localparam int SW    = $clog2(SRC_N);
    localparam int IDX_W = $clog2(BYTE_LIM + 1);

    logic [SRC_N-1:0]   eep_open;
    logic [SRC_N-1:0]   txn_end;
    logic [SRC_N-1:0]   eep_byte_vld;
    logic [IDX_W-1:0]   eep_idx  [SRC_N];
    logic [7:0]         eep_data [SRC_N];
    logic [SRC_N-1:0]   ctl_wr;
    logic [SRC_N*8-1:0] ctl_ptr;
    logic [SRC_N*8-1:0] ctl_data;

    // One parser per source.
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        wpg_txn_parser #(
            .CTRL_ADDR (CTRL_ADDR),
            .EEP_ADDR  (EEP_ADDR),
            .BYTE_LIM  (BYTE_LIM)
        ) u_parse (
            .clk          (clk),
            .rst_n        (rst_n),
            .start        (src_start[g]),
            .stop         (src_stop[g]),
            .addr_vld     (src_addr_vld[g]),
            .addr         (src_addr[g*8 +: 8]),
            .dat_vld      (src_dat_vld[g]),
            .dat          (src_dat[g*8 +: 8]),
            .eep_open     (eep_open[g]),
            .txn_end      (txn_end[g]),
            .eep_byte_vld (eep_byte_vld[g]),
            .eep_idx      (eep_idx[g]),
            .eep_data     (eep_data[g]),
            .ctl_wr       (ctl_wr[g]),
            .ctl_ptr      (ctl_ptr[g*8 +: 8]),
            .ctl_data     (ctl_data[g*8 +: 8])
        );
    end

    wpg_pw_lock #(
        .SRC_N  (SRC_N),
        .PW_OFF (PW_OFF),
        .PW_KEY (PW_KEY)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_ptr  (ctl_ptr),
        .ctl_data (ctl_data),
        .unlocked (gate_open)
    );

    logic [SRC_N-1:0] rej_now;

    wpg_rej_counter #(
        .SRC_N (SRC_N),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rej_now   (rej_now),
        .rej_pulse (rej_pulse),
        .rej_count (rej_count)
    );

    // Path ownership state.
    logic          own_vld;
    logic [SW-1:0] own_src;
    logic          spent;     // owner already rejected once in this transaction

    logic          grant;
    logic [SW-1:0] grant_src;
    logic          release_n;
    logic          spend;
    logic          fwd_n;
    logic          first_n;
    logic [7:0]    data_n;

    // Purpose: decide grants, forwards and rejections for this cycle.
    always_comb begin
        rej_now   = '0;
        grant     = 1'b0;
        grant_src = '0;
        spend     = 1'b0;
        fwd_n     = 1'b0;
        first_n   = 1'b0;
        data_n    = '0;
        release_n = own_vld && txn_end[own_src];
        // Address phases: the lowest index takes a free, open path.
        for (int i = 0; i < SRC_N; i++) begin
            if (eep_open[i]) begin
                if (!gate_open || own_vld || grant) begin
                    rej_now[i] = 1'b1;
                end else begin
                    grant     = 1'b1;
                    grant_src = SW'(i);
                end
            end
        end
        // Owner bytes: check the lock again on each byte, then the byte limit.
        if (own_vld && !spent && eep_byte_vld[own_src]) begin
            if (!gate_open || eep_idx[own_src] >= IDX_W'(BYTE_LIM)) begin
                rej_now[own_src] = 1'b1;
                spend            = 1'b1;
            end else begin
                fwd_n   = 1'b1;
                first_n = (eep_idx[own_src] == '0);
                data_n  = eep_data[own_src];
            end
        end
    end

    // Purpose: hold path ownership across the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_vld <= 1'b0;
            own_src <= '0;
            spent   <= 1'b0;
        end else if (release_n) begin
            own_vld <= 1'b0;
            spent   <= 1'b0;
        end else if (grant) begin
            own_vld <= 1'b1;
            own_src <= grant_src;
            spent   <= 1'b0;
        end else if (spend) begin
            spent <= 1'b1;
        end
    end

    // Purpose: register the forward stream toward the EEPROM master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_vld   <= 1'b0;
            fwd_first <= 1'b0;
            fwd_data  <= '0;
            fwd_src   <= '0;
            fwd_end   <= 1'b0;
        end else begin
            fwd_vld   <= fwd_n;
            fwd_first <= first_n;
            fwd_data  <= data_n;
            fwd_src   <= own_src;
            fwd_end   <= release_n;
        end
    end

    // Nothing is forwarded unless the gate was open in the deciding cycle.
    assert_fwd_needs_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld |-> $past(gate_open));

    // A word-offset marker only comes with a forwarded byte.
    assert_first_with_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_first |-> fwd_vld);

    // A forward is never counted as a rejection in the same cycle.
    assert_fwd_not_rej_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld |-> !(rej_pulse && $past(own_vld) && !$past(|eep_open)));

    // An ended transaction must have owned the path.
    assert_end_needs_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_end |-> $past(own_vld));

endmodule

// File: tb/eeprom_wr_gate_bench.sv
module eeprom_wr_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int CNT_MAX    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       st = '0, sp = '0, av = '0, dv = '0;
    logic [15:0]      ad = '0, dt = '0;
    logic             fwd_vld, fwd_first, fwd_end, rej_pulse, gate_open;
    logic [7:0]       fwd_data;
    logic [0:0]       fwd_src;
    logic [CNT_W-1:0] rej_count;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    int cycles = 0;

    // Captured outputs, sampled 1 time unit after the edge.
    logic c_vld, c_first, c_end, c_rej;
    logic [7:0] c_data;
    logic [0:0] c_src;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_wr_gate #(.CNT_W(CNT_W)) u_eeprom_wr_gate (
        .clk(clk), .rst_n(rst_n),
        .src_start(st), .src_stop(sp), .src_addr_vld(av), .src_addr(ad),
        .src_dat_vld(dv), .src_dat(dt),
        .fwd_vld(fwd_vld), .fwd_first(fwd_first), .fwd_data(fwd_data),
        .fwd_src(fwd_src), .fwd_end(fwd_end), .rej_pulse(rej_pulse),
        .rej_count(rej_count), .gate_open(gate_open)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
        c_vld = fwd_vld; c_first = fwd_first; c_end = fwd_end;
        c_rej = rej_pulse; c_data = fwd_data; c_src = fwd_src;
        st = '0; sp = '0; av = '0; dv = '0;
    endtask

    task automatic bump(input int n);
        exp_cnt = (exp_cnt + n > CNT_MAX) ? CNT_MAX : exp_cnt + n;
    endtask

    task automatic set_addr(input int s, input logic [7:0] a);
        av[s] = 1'b1; ad[s*8 +: 8] = a;
    endtask

    task automatic set_dat(input int s, input logic [7:0] d);
        dv[s] = 1'b1; dt[s*8 +: 8] = d;
    endtask

    task automatic ctl_write(input int s, input logic [7:0] off, input logic [7:0] d);
        st[s] = 1'b1; tick;
        set_addr(s, 8'h98); tick;
        set_dat(s, off); tick;
        set_dat(s, d); tick;
        sp[s] = 1'b1; tick;
    endtask

    // EEPROM write of n bytes from source s; open says the gate is expected open.
    task automatic eep_txn(input int s, input int n, input bit open);
        st[s] = 1'b1; tick;
        set_addr(s, 8'hA0); tick;
        if (!open) begin
            bump(1);
            chk("R5 reject pulse at address", int'(c_rej), 1);
        end
        for (int k = 0; k < n; k++) begin
            set_dat(s, 8'(8'h40 + k)); tick;
            chk("R6/R7 forward valid", int'(c_vld), int'(open && k < 2));
            if (open && k < 2) begin
                chk("R6 first flag", int'(c_first), int'(k == 0));
                chk("R6 data", int'(c_data), 8'h40 + k);
                chk("R6 source", int'(c_src), s);
            end
            if (open && k >= 2) begin
                chk("R7 reject once", int'(c_rej), int'(k == 2));
                if (k == 2) bump(1);
            end
        end
        sp[s] = 1'b1; tick;
        chk("R8 end pulse", int'(c_end), int'(open));
        chk("R5/R7 count", int'(rej_count), exp_cnt);
    endtask

    initial begin
        for (int w = 0; w < 100000; w++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 gate locked", int'(gate_open), 0);
        chk("R1 count zero", int'(rej_count), 0);
        chk("R1 no forward", int'(fwd_vld), 0);

        // R5: locked EEPROM writes are refused.
        eep_txn(0, 2, 0);
        eep_txn(1, 1, 0);

        // R2: sweep every password value.
        for (int v = 0; v < 256; v++) begin
            ctl_write(v % 2, 8'h0F, 8'(v));
            chk("R2 password sweep", int'(gate_open), int'(v == 8'h96));
        end
        ctl_write(0, 8'h0F, 8'h96);
        ctl_write(0, 8'h0F, 8'h00);
        chk("R2 relock with 0x00", int'(gate_open), 0);

        // R13: reads and other devices are ignored.
        st[0] = 1; tick; set_addr(0, 8'hA1); tick; set_dat(0, 8'h12); tick;
        chk("R13 read not forwarded", int'(c_vld), 0);
        sp[0] = 1; tick;
        st[1] = 1; tick; set_addr(1, 8'h50); tick; set_dat(1, 8'h0F); tick;
        set_dat(1, 8'h96); tick;
        chk("R13 other device no forward", int'(c_vld), 0);
        sp[1] = 1; tick;
        chk("R13 count unchanged", int'(rej_count), exp_cnt);
        chk("R13 gate unchanged", int'(gate_open), 0);

        // R4: the key sent through the EEPROM address does not unlock.
        st[0] = 1; tick; set_addr(0, 8'hA0); tick; bump(1);
        set_dat(0, 8'h0F); tick; set_dat(0, 8'h96); tick; sp[0] = 1; tick;
        chk("R4 gate stays locked", int'(gate_open), 0);
        chk("R4 counted as locked reject", int'(rej_count), exp_cnt);

        // R3: pointer walks from several start offsets up to 0x0F and past it.
        for (int off = 12; off <= 15; off++) begin
            st[0] = 1; tick; set_addr(0, 8'h98); tick;
            set_dat(0, 8'(off)); tick;
            for (int p = off; p <= 16; p++) begin
                set_dat(0, (p == 15) ? 8'h96 : 8'h00); tick;
                if (p == 14) chk("R3 not yet at offset", int'(gate_open), 0);
            end
            sp[0] = 1; tick;
            chk("R3 key via pointer walk", int'(gate_open), 1);
            ctl_write(1, 8'h0F, 8'h00);
            chk("R3 relock", int'(gate_open), 0);
        end

        // R6/R7/R8: unlocked writes of 1..4 bytes from both sources.
        ctl_write(0, 8'h0F, 8'h96);
        for (int s = 0; s < 2; s++)
            for (int n = 1; n <= 4; n++)
                eep_txn(s, n, 1);

        // R9: simultaneous address phases, then an intrusion while owned.
        st = 2'b11; tick;
        set_addr(0, 8'hA0); set_addr(1, 8'hA0); tick; bump(1);
        chk("R9 loser rejected", int'(c_rej), 1);
        set_dat(0, 8'h5A); set_dat(1, 8'hA5); tick;
        chk("R9 winner forwarded", int'(c_vld), 1);
        chk("R9 winner data", int'(c_data), 8'h5A);
        chk("R9 winner is source 0", int'(c_src), 0);
        sp[1] = 1; tick;
        chk("R8 non-owner stop no end", int'(c_end), 0);
        st[1] = 1; tick; set_addr(1, 8'hA0); tick; bump(1);
        chk("R9 intruder rejected", int'(c_rej), 1);
        set_dat(1, 8'h77); tick;
        chk("R9 intruder byte dropped", int'(c_vld), 0);
        sp[1] = 1; tick;
        sp[0] = 1; tick;
        chk("R8 owner stop ends", int'(c_end), 1);
        chk("R9 count", int'(rej_count), exp_cnt);

        // R10: relock lands in the same cycle as the owner's word offset.
        st[0] = 1; tick; set_addr(0, 8'hA0); tick;
        st[1] = 1; tick; set_addr(1, 8'h98); tick; set_dat(1, 8'h0F); tick;
        set_dat(0, 8'h33); set_dat(1, 8'h00); tick;
        chk("R10 same-cycle byte forwarded", int'(c_vld), 1);
        chk("R10 same-cycle data", int'(c_data), 8'h33);
        chk("R10 gate now locked", int'(gate_open), 0);
        set_dat(0, 8'h44); tick; bump(1);
        chk("R10 next byte rejected", int'(c_rej), 1);
        chk("R10 next byte not forwarded", int'(c_vld), 0);
        set_dat(0, 8'h55); tick;
        chk("R10 later byte not counted", int'(c_rej), 0);
        sp = 2'b11; tick;
        chk("R10 owner end", int'(c_end), 1);
        chk("R10 count", int'(rej_count), exp_cnt);

        // R11: simultaneous password stores, source 0 wins.
        st = 2'b11; tick;
        set_addr(0, 8'h98); set_addr(1, 8'h98); tick;
        set_dat(0, 8'h0F); set_dat(1, 8'h0F); tick;
        set_dat(0, 8'h96); set_dat(1, 8'h00); tick;
        chk("R11 source 0 key wins", int'(gate_open), 1);
        sp = 2'b11; tick;
        st = 2'b11; tick;
        set_addr(0, 8'h98); set_addr(1, 8'h98); tick;
        set_dat(0, 8'h0F); set_dat(1, 8'h0F); tick;
        set_dat(0, 8'h00); set_dat(1, 8'h96); tick;
        chk("R11 source 0 relock wins", int'(gate_open), 0);
        sp = 2'b11; tick;

        // R12: two rejections in one cycle, then saturation.
        st = 2'b11; tick;
        set_addr(0, 8'hA0); set_addr(1, 8'hA0); tick; bump(2);
        chk("R12 double pulse", int'(c_rej), 1);
        chk("R12 count plus two", int'(rej_count), exp_cnt);
        sp = 2'b11; tick;
        for (int r = 0; r < CNT_MAX + 2; r++) eep_txn(r % 2, 1, 0);
        chk("R12 saturated", int'(rej_count), CNT_MAX);

        finish_up;
    end

    always @(posedge clk) cycles <= cycles + 1;

endmodule